// File: doc/BRIEF.md
# Linear FM Chirp Synthesiser

This block generates one baseband linear-FM pulse each time it is started, by direct digital synthesis. A signed chirp rate is added on every clock to a frequency register, and the frequency register is added on every clock to a 16-bit phase register. The phase therefore grows as a quadratic in time, and the instantaneous frequency moves linearly from the programmed start value. The upper phase bits address a computed sine table. That table gives an in-phase (sine) sample and a quadrature (cosine) sample of the same phase on the same clock.

The pulse lasts a programmed number of clocks. Outside it, both samples are zero and the registers hold still. A typical setting starts at a negative frequency equal to minus half the swept bandwidth, so the frequency passes through zero at mid-pulse and the envelope of the waveform is mirror-symmetric about the centre. The converters, filters and mixers that follow the block are outside it.

Top module: `chirp_gen`

## Requirements
- R1: While reset is held, the outputs are cleared to valid 0, done 0, I 0 and Q 0 from the first clock edge.
- R2: A start strobe sampled at edge E0 with a non-zero length L produces exactly L valid samples, on contiguous cycles. Sample n (n = 0..L-1) is presented after edge E(n+1), so the table adds one cycle.
- R3: Sample n uses the phase P(n) = (n*F0 + K*n*(n-1)/2) mod 65536. F0 is the 16-bit two's-complement start frequency and K is the 16-bit two's-complement rate. The table address is P(n) bits 15..6.
- R4: For address a, the table value S(a) uses u = a mod 512 and p = u*(512-u), and equals round(2047*16*p / (5*512*512 - 4*p)). S(a) is negated when a >= 512. I = S(a) and Q = S((a+256) mod 1024), both signed 12-bit.
- R5: On every cycle without a valid sample, I and Q are zero.
- R6: Done is high for exactly one cycle, on the cycle of the last valid sample of a pulse.
- R7: A start strobe sampled while a pulse is still being generated is ignored. This includes the edge that produces the last sample.
- R8: A start strobe with a length of zero starts no pulse.
- R9: The rate, start frequency and length are captured at the accepted start. Changing those inputs during a pulse has no effect on it.
- R10: With F0 = -K*(L-1)/2 and K even, the I samples satisfy I(n) = I(L-n) for n = 1..L-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled on the rising edge |
| rate_i | input | 16 | Signed chirp rate added to frequency each clock |
| fstart_i | input | 16 | Signed start frequency |
| len_i | input | 16 | Pulse length in samples |
| i_o | output | 12 | Signed in-phase (sine) sample |
| q_o | output | 12 | Signed quadrature (cosine) sample |
| valid_o | output | 1 | Sample valid |
| done_o | output | 1 | Last sample of the pulse |

## Verification
Errors in the frequency register, the phase register or the captured rate do not stay hidden. From the next sample on, the table address moves away from the quadratic law, so the port samples diverge within one or two cycles. They diverge more as the pulse goes on, because each error is integrated again. A counter that is out by one shows up at the pulse edges: the valid window is one cycle too short or too long, or done comes on the wrong sample. A start that is wrongly accepted mid-pulse resets the phase at once and shows up in the next sample. The reference model in the bench recomputes each sample from the closed-form phase, so every clock of every pulse, and every idle cycle, is compared.

// File: rtl/chirp_pkg.sv
// Package chirp_pkg
// Shared constants and the elaboration-time sine function for the chirp
// synthesiser. The sine uses a rational approximation in integer arithmetic,
// so the table can be built as constants with no real-number support.
package chirp_pkg;

    localparam int PHASE_W = 16;
    localparam int SAMP_W  = 12;

    // Signed table sample for address addr of a 2^addr_w entry full cycle.
    function automatic int sine_sample(input int addr, input int addr_w, input int amp);
        longint half_n;
        longint u;
        longint p;
        longint num;
        longint den;
        longint mag;
        half_n = longint'(1) << (addr_w - 1);
        u      = longint'(addr) % half_n;
        p      = u * (half_n - u);
        num    = longint'(amp) * 16 * p;
        den    = 5 * half_n * half_n - 4 * p;
        mag    = (num + den / 2) / den;
        if (longint'(addr) >= half_n) begin
            mag = -mag;
        end
        return int'(mag);
    endfunction

endpackage

// File: rtl/chirp_ctrl.sv
// Module chirp_ctrl
// Pulse window control. A start is accepted when no pulse is running and the
// requested length is non-zero. The length is then captured and a counter runs
// for that many clocks. Assumes start_i and len_i are synchronous to clk.
module chirp_ctrl #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             accept_o,
    output logic             run_o,
    output logic             last_o
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             run_q;

    // Accept a start only while idle and with a non-zero length.
    always_comb begin
        accept_o = start_i && !run_q && (len_i != '0);
    end

    // Final sample of the window.
    always_comb begin
        last_o = run_q && (cnt_q == len_q - 1'b1);
    end

    assign run_o = run_q;

    // Window counter: load on accept, count while running, stop after the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            len_q <= '0;
        end else if (accept_o) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            len_q <= len_i;
        end else if (run_q) begin
            if (last_o) begin
                run_q <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !last_o) |=> (run_q && cnt_q == $past(cnt_q) + 1'b1));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !last_o) |=> $stable(len_q));

endmodule

// File: rtl/chirp_accum.sv
// Module chirp_accum
// Cascaded integrators. The frequency register adds the captured rate on each
// running clock, and the phase register adds the frequency. Both wrap
// modulo 2^PHASE_W. Only the table address bits of the phase leave the module.
module chirp_accum #(
    parameter int PHASE_W = 16,
    parameter int ADDR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              run_i,
    input  logic [PHASE_W-1:0] rate_i,
    input  logic [PHASE_W-1:0] fstart_i,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [PHASE_W-1:0] rate_q;
    logic [PHASE_W-1:0] freq_q;
    logic [PHASE_W-1:0] phase_q;

    // Capture on load, then integrate rate into frequency and frequency into phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= '0;
            freq_q  <= '0;
            phase_q <= '0;
        end else if (load_i) begin
            rate_q  <= rate_i;
            freq_q  <= fstart_i;
            phase_q <= '0;
        end else if (run_i) begin
            freq_q  <= freq_q + rate_q;
            phase_q <= phase_q + freq_q;
        end
    end

    assign addr_o = phase_q[PHASE_W-1 -: ADDR_W];

    // R3
    phase_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> (phase_q == PHASE_W'($past(phase_q) + $past(freq_q))));

    // R9
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(rate_q));

endmodule

// File: rtl/chirp_sincos.sv
// Module chirp_sincos
// Phase-to-amplitude stage. A full-cycle sine table is built at elaboration.
// Two reads per clock give sine at the address and cosine at the address plus
// a quarter cycle. The outputs are registered, so valid and done get the same
// single cycle of latency as the samples. Samples are forced to zero outside
// the window.
module chirp_sincos #(
    parameter int ADDR_W = 10,
    parameter int SAMP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic                     last_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic signed [SAMP_W-1:0] i_o,
    output logic signed [SAMP_W-1:0] q_o,
    output logic                     valid_o,
    output logic                     done_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int AMP   = (1 << (SAMP_W - 1)) - 1;
    localparam logic [ADDR_W-1:0] QTR = ADDR_W'(DEPTH / 4);

    logic signed [SAMP_W-1:0] tbl [DEPTH];
    logic [ADDR_W-1:0]        cos_addr;

    // Fill the table with constants computed from the shared function.
    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
        assign tbl[k] = SAMP_W'(chirp_pkg::sine_sample(k, ADDR_W, AMP));
    end

    // Cosine address: a quarter-cycle ahead of the sine address.
    always_comb begin
        cos_addr = addr_i + QTR;
    end

    // Registered lookup with the window gate applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_o     <= '0;
            q_o     <= '0;
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            i_o     <= run_i ? tbl[addr_i]   : '0;
            q_o     <= run_i ? tbl[cos_addr] : '0;
            valid_o <= run_i;
            done_o  <= run_i && last_i;
        end
    end

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (i_o == '0 && q_o == '0));

endmodule

// File: rtl/chirp_gen.sv
// Module chirp_gen
// Top level of the linear FM chirp synthesiser: window control, cascaded
// integrators and the sine/cosine table. Assumes one clock domain and a
// synchronous active-low reset. The rate and start frequency are 16-bit
// two's complement, in units of 2^-16 cycles per sample.
module chirp_gen #(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [chirp_pkg::PHASE_W-1:0]        rate_i,
    input  logic [chirp_pkg::PHASE_W-1:0]        fstart_i,
    input  logic [LEN_W-1:0]                     len_i,
    output logic signed [chirp_pkg::SAMP_W-1:0]  i_o,
    output logic signed [chirp_pkg::SAMP_W-1:0]  q_o,
    output logic                                 valid_o,
    output logic                                 done_o
);

    logic              accept;
    logic              run;
    logic              last;
    logic [ADDR_W-1:0] addr;

    chirp_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .len_i    (len_i),
        .accept_o (accept),
        .run_o    (run),
        .last_o   (last)
    );

    chirp_accum #(.PHASE_W(chirp_pkg::PHASE_W), .ADDR_W(ADDR_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .run_i    (run),
        .rate_i   (rate_i),
        .fstart_i (fstart_i),
        .addr_o   (addr)
    );

    chirp_sincos #(.ADDR_W(ADDR_W), .SAMP_W(chirp_pkg::SAMP_W)) u_sincos (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .last_i  (last),
        .addr_i  (addr),
        .i_o     (i_o),
        .q_o     (q_o),
        .valid_o (valid_o),
        .done_o  (done_o)
    );

    // R2
    first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(accept, 2));

    // R6
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !valid_o);

    // R6
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);

endmodule

// File: tb/test_chirp_gen.sv
// Bench for chirp_gen. A behavioural model recomputes each sample from the
// closed-form phase law and is compared at every falling edge.
module test_chirp_gen;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [15:0]        rate_i = '0;
    logic [15:0]        fstart_i = '0;
    logic [15:0]        len_i = '0;
    logic signed [11:0] i_o;
    logic signed [11:0] q_o;
    logic               valid_o;
    logic               done_o;

    int checks = 0;
    int failures = 0;

    // model state
    int m_act = 0;
    int m_n = 0;
    int m_len = 0;
    int m_f0 = 0;
    int m_k = 0;
    int e_valid = 0;
    int e_done = 0;
    int e_i = 0;
    int e_q = 0;

    int vcount = 0;
    int dcount = 0;
    int collect = 0;
    int iq[$];

    always #10 clk = ~clk;

    chirp_gen i_chirp_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rate_i   (rate_i),
        .fstart_i (fstart_i),
        .len_i    (len_i),
        .i_o      (i_o),
        .q_o      (q_o),
        .valid_o  (valid_o),
        .done_o   (done_o)
    );

    function automatic int ref_sine(input int a);
        longint u;
        longint p;
        longint num;
        longint den;
        longint m;
        u   = a % 512;
        p   = u * (512 - u);
        num = 2047 * 16 * p;
        den = 5 * 512 * 512 - 4 * p;
        m   = (num + den / 2) / den;
        return (a >= 512) ? -int'(m) : int'(m);
    endfunction

    function automatic int ref_addr(input int n, input int f0, input int k);
        longint ph;
        ph = longint'(n) * f0 + longint'(k) * ((longint'(n) * (n - 1)) / 2);
        ph = ph & 65535;
        return int'(ph >> 6);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advance one sample per clock from the closed-form law.
    always @(posedge clk) begin
        int busy;
        int a;
        if (!rst_n) begin
            m_act = 0; e_valid = 0; e_done = 0; e_i = 0; e_q = 0;
        end else begin
            busy = m_act;
            if (m_act != 0) begin
                a = ref_addr(m_n, m_f0, m_k);
                e_valid = 1;
                e_done  = (m_n == m_len - 1) ? 1 : 0;
                e_i     = ref_sine(a);
                e_q     = ref_sine((a + 256) % 1024);
                m_n++;
                if (m_n == m_len) m_act = 0;
            end else begin
                e_valid = 0; e_done = 0; e_i = 0; e_q = 0;
            end
            if (busy == 0 && start_i && len_i != 0) begin
                m_act = 1;
                m_n   = 0;
                m_len = int'(len_i);
                m_f0  = int'($signed(fstart_i));
                m_k   = int'($signed(rate_i));
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(valid_o == e_valid[0], "R2 valid", valid_o, e_valid);
            chk(done_o == e_done[0], "R6 done", done_o, e_done);
            chk(int'(i_o) == e_i, e_valid != 0 ? "R3/R4 I sample" : "R5 idle I", i_o, e_i);
            chk(int'(q_o) == e_q, e_valid != 0 ? "R4 Q sample" : "R5 idle Q", q_o, e_q);
            if (valid_o) vcount++;
            if (done_o) dcount++;
            if (collect != 0 && valid_o) iq.push_back(int'(i_o));
        end
    end

    task automatic start_pulse(input int k, input int f0, input int len);
        @(negedge clk);
        start_i  = 1'b1;
        rate_i   = 16'(k);
        fstart_i = 16'(f0);
        len_i    = 16'(len);
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_act != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int mism;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0 && done_o == 1'b0, "R1 reset flags", {valid_o, done_o}, 0);
        chk(i_o == 0 && q_o == 0, "R1 reset samples", i_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 symmetric sweep, with R7 and R9 disturbances mid-pulse
        vcount = 0; dcount = 0; collect = 1; iq.delete();
        start_pulse(4, -5998, 3000);
        repeat (100) @(negedge clk);
        start_i = 1'b1; rate_i = 16'd999; fstart_i = 16'd1234; len_i = 16'd7;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rate_i = 16'hFFF0; fstart_i = 16'h4000; len_i = 16'd3;
        wait_idle();
        collect = 0;
        chk(vcount == 3000, "R2 R7 R9 sample count", vcount, 3000);
        chk(dcount == 1, "R6 single done", dcount, 1);
        mism = 0;
        if (iq.size() == 3000) begin
            for (int n = 1; n < 3000; n++) if (iq[n] != iq[3000 - n]) mism++;
        end else mism = -1;
        chk(mism == 0, "R10 symmetry", mism, 0);

        // R6 length one pulse
        vcount = 0; dcount = 0;
        start_pulse(100, 300, 1);
        wait_idle();
        chk(vcount == 1 && dcount == 1, "R6 length one", vcount * 10 + dcount, 11);

        // R8 zero length ignored
        vcount = 0;
        start_pulse(5, 5, 0);
        repeat (10) @(negedge clk);
        chk(vcount == 0, "R8 zero length", vcount, 0);

        // R3 down sweep, negative rate with wrap
        vcount = 0;
        start_pulse(-7, 12345, 500);
        wait_idle();
        chk(vcount == 500, "R3 down sweep count", vcount, 500);

        // R7 start held high: pulses separated by exactly one gap
        vcount = 0; dcount = 0;
        @(negedge clk);
        start_i = 1'b1; rate_i = 16'd37; fstart_i = 16'hF000; len_i = 16'd20;
        repeat (62) @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(dcount == 3, "R7 held start pulses", dcount, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule